// File: doc/BRIEF.md
# Operand Hazard Resolver for an In-Order Five-Stage Pipeline

This block decides, once per cycle, how each source operand of the instruction waiting in the issue stage gets its value. The pipeline runs fetch, issue, execute, memory and writeback. The block keeps its own short record of the two older instructions, the one now in execute and the one now in memory. It compares their destination registers with the issue-stage operands. For each operand it names a source: the register file, the near producer (the instruction now in execute) or the far producer (the instruction now in memory).

A producer can belong to one of two result classes. An early result is ready at the end of execute, as for plain ALU work. A late result is ready only at the end of memory, as for loads, multiplies, multiply-accumulates, divides and the longer DSP operations. Each operand also belongs to one of two need classes. Most operands are needed at the start of execute. Some are needed only at memory: store data, or the accumulator of a multiply-accumulate. The decoder supplies these classes.

When an execute-need operand depends on a late producer directly ahead of it, the block raises `stall` for one cycle. The issue stage holds, and an empty slot enters execute. A producer may write two registers, for example the quotient and the remainder of a combined divide. Both registers are checked. Register 0 never creates a dependence.

Top module: `hzd_unit`

## Requirements
- R1: Out of reset no older instruction is tracked, so for any issue request `stall` is 0 and every operand select is 00.
- R2: Operand k's select sits at `fwd_sel[2k+1:2k]`, with 00 meaning register file, 01 the near producer (now in execute) and 10 the far producer (now in memory). An execute-need operand that reads the destination of an early-class producer directly ahead gets 01 and does not stall.
- R3: An execute-need operand (`iss_src_late`=0) that reads the destination of a late-class producer (`iss_rdy_late`=1) directly ahead raises `stall` for exactly one cycle. In the next cycle the same request gets select 10 and no stall.
- R4: A memory-need operand (`iss_src_late`=1) never causes a stall, even when it reads a late producer directly ahead. It still gets select 01.
- R5: An operand that reads the destination of the producer two ahead gets select 10 and no stall, whatever that producer's result class.
- R6: A producer can write two registers, with destination j at `iss_dst_idx[RW*j +: RW]` enabled by `iss_dst_wr[j]`. Each written destination is checked on its own.
- R7: Register index 0 never matches, either as a source or as a written destination.
- R8: When both the near and the far producer write the register an operand reads, the near producer is selected (01).
- R9: A stalled request does not enter execute; an empty slot enters in its place. One cycle after the request is released, the far slot holds no producer, so a read of the old late producer's register gets 00.
- R10: An invalid request (`iss_vld`=0) or an unused operand (`iss_src_use`=0) causes no stall and gets select 00. An invalid request leaves an empty slot in execute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | An instruction is presented in the issue stage |
| iss_src_idx | input | NSRC*RW | Source register indices, operand k at [RW*k +: RW] |
| iss_src_use | input | NSRC | Operand k is read |
| iss_src_late | input | NSRC | Operand k is needed only at memory |
| iss_dst_idx | input | NDST*RW | Destination register indices of the issuing instruction |
| iss_dst_wr | input | NDST | Destination j is written |
| iss_rdy_late | input | 1 | Result of the issuing instruction is ready only after memory |
| stall | output | 1 | Hold the issue stage this cycle and send an empty slot to execute |
| fwd_sel | output | 2*NSRC | Per-operand source select (00 file, 01 near, 10 far) |

## Verification
Short directed sequences place a producer one or two slots ahead of the consumer. They set the result and need classes on each side, so they separate the one-cycle stall from plain forwarding, the near source from the far one, and a late operand that tolerates a late producer from an early operand that does not. Further sequences write through the second destination only, write or read register 0, and let both slots match at once. A long sweep then drives pseudo-random requests over only four register indices, which makes matches dense. It compares every select and every stall with an arithmetic model of the two tracked slots. That sweep exposes wrong priority, a missing bubble or a dropped destination check as soon as any such case occurs.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // Source chosen for one issue-stage operand
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_NEAR    = 2'b01,
    SRC_FAR     = 2'b10
  } fwd_src_e;

endpackage

// File: rtl/hzd_track.sv
module hzd_track #(
  parameter int RW   = 5,
  parameter int NDST = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [NDST*RW-1:0] in_dst,
  input  logic [NDST-1:0]    in_wr,
  input  logic               in_late,
  output logic               ex_vld,
  output logic [NDST*RW-1:0] ex_dst,
  output logic [NDST-1:0]    ex_wr,
  output logic               ex_late,
  output logic               mm_vld,
  output logic [NDST*RW-1:0] mm_dst,
  output logic [NDST-1:0]    mm_wr
);

  logic [NDST-1:0] wr_masked;
  logic            ex_vld_d, mm_vld_d;
  logic            ex_en, mm_en;

  // a write to register 0 is not a real result
  for (genvar g = 0; g < NDST; g++) begin : g_mask
    assign wr_masked[g] = in_wr[g] & (|in_dst[g*RW +: RW]);
  end

  always_comb begin
    ex_vld_d = push;
    mm_vld_d = ex_vld;
    ex_en    = push;
    mm_en    = ex_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_vld <= 1'b0;
      mm_vld <= 1'b0;
    end else begin
      ex_vld <= ex_vld_d;
      mm_vld <= mm_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_dst  <= '0;
      ex_wr   <= '0;
      ex_late <= 1'b0;
    end else if (ex_en) begin
      ex_dst  <= in_dst;
      ex_wr   <= wr_masked;
      ex_late <= in_late;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm_dst <= '0;
      mm_wr  <= '0;
    end else if (mm_en) begin
      mm_dst <= ex_dst;
      mm_wr  <= ex_wr;
    end
  end

endmodule

// File: rtl/hzd_match.sv
module hzd_match
  import hzd_pkg::*;
#(
  parameter int RW   = 5,
  parameter int NDST = 2
) (
  input  logic [RW-1:0]      src_idx,
  input  logic               src_rd,
  input  logic               src_late,
  input  logic               ex_vld,
  input  logic [NDST*RW-1:0] ex_dst,
  input  logic [NDST-1:0]    ex_wr,
  input  logic               ex_late,
  input  logic               mm_vld,
  input  logic [NDST*RW-1:0] mm_dst,
  input  logic [NDST-1:0]    mm_wr,
  output logic [1:0]         sel,
  output logic               hold
);

  logic [NDST-1:0] ex_hit_v, mm_hit_v;
  logic            live, near, far;
  fwd_src_e        src;

  for (genvar g = 0; g < NDST; g++) begin : g_cmp
    assign ex_hit_v[g] = ex_wr[g] & (ex_dst[g*RW +: RW] == src_idx);
    assign mm_hit_v[g] = mm_wr[g] & (mm_dst[g*RW +: RW] == src_idx);
  end

  always_comb begin
    live = src_rd & (|src_idx);
    near = live & ex_vld & (|ex_hit_v);
    far  = live & mm_vld & (|mm_hit_v);
    if (near)     src = SRC_NEAR;
    else if (far) src = SRC_FAR;
    else          src = SRC_REGFILE;
    sel  = src;
    hold = near & ex_late & ~src_late;
  end

endmodule

// File: rtl/hzd_unit.sv
module hzd_unit #(
  parameter int NSRC = 3,
  parameter int NDST = 2,
  parameter int RW   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_vld,
  input  logic [NSRC*RW-1:0] iss_src_idx,
  input  logic [NSRC-1:0]    iss_src_use,
  input  logic [NSRC-1:0]    iss_src_late,
  input  logic [NDST*RW-1:0] iss_dst_idx,
  input  logic [NDST-1:0]    iss_dst_wr,
  input  logic               iss_rdy_late,
  output logic               stall,
  output logic [2*NSRC-1:0]  fwd_sel
);

  logic               ex_vld, ex_late, mm_vld, push;
  logic [NDST*RW-1:0] ex_dst, mm_dst;
  logic [NDST-1:0]    ex_wr, mm_wr;
  logic [NSRC-1:0]    hold_v;

  hzd_track #(.RW(RW), .NDST(NDST)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .in_dst  (iss_dst_idx),
    .in_wr   (iss_dst_wr),
    .in_late (iss_rdy_late),
    .ex_vld  (ex_vld),
    .ex_dst  (ex_dst),
    .ex_wr   (ex_wr),
    .ex_late (ex_late),
    .mm_vld  (mm_vld),
    .mm_dst  (mm_dst),
    .mm_wr   (mm_wr)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_op
    hzd_match #(.RW(RW), .NDST(NDST)) u_match (
      .src_idx  (iss_src_idx[k*RW +: RW]),
      .src_rd   (iss_vld & iss_src_use[k]),
      .src_late (iss_src_late[k]),
      .ex_vld   (ex_vld),
      .ex_dst   (ex_dst),
      .ex_wr    (ex_wr),
      .ex_late  (ex_late),
      .mm_vld   (mm_vld),
      .mm_dst   (mm_dst),
      .mm_wr    (mm_wr),
      .sel      (fwd_sel[2*k +: 2]),
      .hold     (hold_v[k])
    );
  end

  always_comb begin
    stall = |hold_v;
    push  = iss_vld & ~stall;
  end

endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
  parameter int NSRC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_vld,
  input logic [NSRC-1:0]   iss_src_use,
  input logic [NSRC-1:0]   iss_src_late,
  input logic              stall,
  input logic [2*NSRC-1:0] fwd_sel,
  input logic              ex_vld,
  input logic              ex_late,
  input logic              mm_vld
);

  // R10
  stall_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> iss_vld);

  // R3
  stall_needs_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_vld && ex_late));

  // R3
  one_cycle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R9
  bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_vld);

  // R4
  late_ops_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && (&(~iss_src_use | iss_src_late))) |-> !stall);

  // R5
  slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_vld |=> mm_vld);

  for (genvar k = 0; k < NSRC; k++) begin : g_sel
    // R2
    sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fwd_sel[2*k +: 2]));
  end

endmodule

bind hzd_unit hzd_unit_chk #(.NSRC(NSRC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .iss_vld      (iss_vld),
  .iss_src_use  (iss_src_use),
  .iss_src_late (iss_src_late),
  .stall        (stall),
  .fwd_sel      (fwd_sel),
  .ex_vld       (ex_vld),
  .ex_late      (ex_late),
  .mm_vld       (mm_vld)
);

// File: tb/hzd_unit_test.sv
module hzd_unit_test;
  localparam int NSRC = 3;
  localparam int NDST = 2;
  localparam int RW   = 5;

  logic               clk, rst_n;
  logic               iss_vld;
  logic [NSRC*RW-1:0] iss_src_idx;
  logic [NSRC-1:0]    iss_src_use, iss_src_late;
  logic [NDST*RW-1:0] iss_dst_idx;
  logic [NDST-1:0]    iss_dst_wr;
  logic               iss_rdy_late;
  logic               stall;
  logic [2*NSRC-1:0]  fwd_sel;

  int checks = 0;
  int fails  = 0;

  // bench model of the two tracked slots
  bit m_ex_vld, m_ex_late, m_mm_vld;
  int m_ex_dst [NDST];
  bit m_ex_wr  [NDST];
  int m_mm_dst [NDST];
  bit m_mm_wr  [NDST];

  hzd_unit #(.NSRC(NSRC), .NDST(NDST), .RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_src_idx(iss_src_idx),
    .iss_src_use(iss_src_use), .iss_src_late(iss_src_late),
    .iss_dst_idx(iss_dst_idx), .iss_dst_wr(iss_dst_wr),
    .iss_rdy_late(iss_rdy_late), .stall(stall), .fwd_sel(fwd_sel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit hit_ex(input int r);
    bit h = 0;
    for (int j = 0; j < NDST; j++) if (m_ex_wr[j] && m_ex_dst[j] == r) h = 1;
    return (r != 0) && m_ex_vld && h;
  endfunction

  function automatic bit hit_mm(input int r);
    bit h = 0;
    for (int j = 0; j < NDST; j++) if (m_mm_wr[j] && m_mm_dst[j] == r) h = 1;
    return (r != 0) && m_mm_vld && h;
  endfunction

  // set issue request; sources a,b,c; destinations d0,d1
  task automatic req(input bit v, input int a, input int b, input int c,
                     input bit [2:0] use_m, input bit [2:0] late_m,
                     input int d0, input int d1, input bit [1:0] wr_m,
                     input bit rl);
    iss_vld      = v;
    iss_src_idx  = {c[RW-1:0], b[RW-1:0], a[RW-1:0]};
    iss_src_use  = use_m;
    iss_src_late = late_m;
    iss_dst_idx  = {d1[RW-1:0], d0[RW-1:0]};
    iss_dst_wr   = wr_m;
    iss_rdy_late = rl;
  endtask

  // check outputs against the model, then advance one clock
  task automatic step(input string tag);
    bit e_stall = 0;
    #1;
    for (int k = 0; k < NSRC; k++) begin
      int  r  = int'(iss_src_idx[k*RW +: RW]);
      bit  rd = iss_vld && iss_src_use[k];
      int  es = 0;
      if (rd && hit_ex(r)) begin
        es = 1;
        if (m_ex_late && !iss_src_late[k]) e_stall = 1;
      end else if (rd && hit_mm(r)) es = 2;
      chk({tag, " sel"}, int'(fwd_sel[2*k +: 2]), es);
    end
    chk({tag, " stall"}, int'(stall), int'(e_stall));
    @(posedge clk);
    m_mm_vld = m_ex_vld;
    for (int j = 0; j < NDST; j++) begin
      m_mm_dst[j] = m_ex_dst[j];
      m_mm_wr[j]  = m_ex_wr[j];
    end
    m_ex_vld = iss_vld && !e_stall;
    if (m_ex_vld) begin
      m_ex_late = iss_rdy_late;
      for (int j = 0; j < NDST; j++) begin
        m_ex_dst[j] = int'(iss_dst_idx[j*RW +: RW]);
        m_ex_wr[j]  = iss_dst_wr[j];
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit [31:0] lfsr;
    m_ex_vld = 0; m_mm_vld = 0; m_ex_late = 0;
    for (int j = 0; j < NDST; j++) begin
      m_ex_dst[j] = 0; m_ex_wr[j] = 0; m_mm_dst[j] = 0; m_mm_wr[j] = 0;
    end
    rst_n = 1'b0;
    req(1, 1, 2, 3, 3'b111, 3'b000, 0, 0, 2'b00, 0);
    #2;
    chk("R1 stall in reset", int'(stall), 0);
    chk("R1 sel in reset", int'(fwd_sel), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: nothing tracked after reset
    step("R1");

    // R2: early producer directly ahead
    req(1, 0, 0, 0, 3'b000, 3'b000, 5, 0, 2'b01, 0); step("R2 prod");
    req(1, 5, 0, 0, 3'b001, 3'b000, 0, 0, 2'b00, 0);
    #1; chk("R2 near sel", int'(fwd_sel[1:0]), 1); chk("R2 no stall", int'(stall), 0);
    step("R2");

    // R3: late producer directly ahead, one-cycle stall then far
    req(1, 0, 0, 0, 3'b000, 3'b000, 6, 0, 2'b01, 1); step("R3 prod");
    req(1, 6, 0, 0, 3'b001, 3'b000, 7, 0, 2'b01, 0);
    #1; chk("R3 stall", int'(stall), 1);
    step("R3 stalled");
    #1; chk("R3 release", int'(stall), 0); chk("R3 far sel", int'(fwd_sel[1:0]), 2);
    step("R3 release");

    // R9: bubble behind the released instruction
    req(1, 6, 7, 0, 3'b011, 3'b000, 0, 0, 2'b00, 0);
    #1; chk("R9 old producer gone", int'(fwd_sel[1:0]), 0);
    chk("R9 released is near", int'(fwd_sel[3:2]), 1);
    step("R9");

    // R4: accumulator / store data needed late, no stall
    req(1, 0, 0, 0, 3'b000, 3'b000, 8, 0, 2'b01, 1); step("R4 prod");
    req(1, 9, 0, 8, 3'b101, 3'b100, 9, 0, 2'b01, 1);
    #1; chk("R4 no stall", int'(stall), 0); chk("R4 near sel", int'(fwd_sel[5:4]), 1);
    step("R4");

    // R5: late producer two ahead
    req(1, 0, 0, 0, 3'b000, 3'b000, 10, 0, 2'b01, 1); step("R5 prod");
    req(1, 1, 0, 0, 3'b001, 3'b000, 2, 0, 2'b01, 0); step("R5 filler");
    req(1, 0, 10, 0, 3'b010, 3'b000, 0, 0, 2'b00, 0);
    #1; chk("R5 far sel", int'(fwd_sel[3:2]), 2); chk("R5 no stall", int'(stall), 0);
    step("R5");

    // R6: second destination of a two-result producer
    req(1, 0, 0, 0, 3'b000, 3'b000, 11, 12, 2'b11, 1); step("R6 prod");
    req(1, 0, 12, 0, 3'b010, 3'b000, 0, 0, 2'b00, 0);
    #1; chk("R6 stall on second dest", int'(stall), 1);
    step("R6 stall"); step("R6 release");
    req(1, 0, 0, 0, 3'b000, 3'b000, 11, 12, 2'b10, 1); step("R6 prod2");
    req(1, 11, 0, 0, 3'b001, 3'b000, 0, 0, 2'b00, 0);
    #1; chk("R6 disabled dest ignored", int'(stall), 0);
    step("R6");

    // R7: register 0 never a dependence
    req(1, 0, 0, 0, 3'b000, 3'b000, 0, 0, 2'b11, 1); step("R7 prod");
    req(1, 0, 0, 0, 3'b111, 3'b000, 0, 0, 2'b00, 0);
    #1; chk("R7 no stall", int'(stall), 0); chk("R7 sel", int'(fwd_sel), 0);
    step("R7");

    // R8: both slots match, near wins
    req(1, 0, 0, 0, 3'b000, 3'b000, 13, 0, 2'b01, 0); step("R8 p1");
    req(1, 0, 0, 0, 3'b000, 3'b000, 13, 0, 2'b01, 0); step("R8 p2");
    req(1, 13, 0, 0, 3'b001, 3'b000, 0, 0, 2'b00, 0);
    #1; chk("R8 near priority", int'(fwd_sel[1:0]), 1);
    step("R8");

    // R10: invalid request and unused operand
    req(1, 0, 0, 0, 3'b000, 3'b000, 14, 0, 2'b01, 1); step("R10 prod");
    req(0, 14, 14, 14, 3'b111, 3'b000, 15, 0, 2'b01, 1);
    #1; chk("R10 invalid no stall", int'(stall), 0); chk("R10 invalid sel", int'(fwd_sel), 0);
    step("R10 invalid");
    req(1, 0, 0, 0, 3'b000, 3'b000, 14, 0, 2'b01, 1); step("R10 prod2");
    req(1, 14, 0, 0, 3'b000, 3'b000, 0, 0, 2'b00, 0);
    #1; chk("R10 unused no stall", int'(stall), 0); chk("R10 unused sel", int'(fwd_sel), 0);
    step("R10");
    req(1, 15, 0, 0, 3'b001, 3'b000, 0, 0, 2'b00, 0);
    step("R10 empty slot");

    // dense sweep over four register indices
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 4000; n++) begin
      bit [31:0] r;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r = lfsr * 32'd2654435761;
      req(r[0] | r[1], int'(r[3:2]), int'(r[5:4]), int'(r[7:6]), r[10:8],
          r[13:11], int'(r[15:14]), int'(r[17:16]), r[19:18], r[20]);
      step("sweep R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule